// File: doc/BRIEF.md
# Banded Toeplitz Matrix by Data Column Multiplier

This block multiplies a banded Toeplitz coefficient matrix by a dense data matrix, one data column at a time. The band holds 2·HALF+1 non-zero diagonals, so the whole matrix is described by that many coefficients. Each coefficient lives in its own processing element. Software loads the coefficients through a small write port before any data arrives. The block is meant to be the front stage of a cascade of matrix products that builds a matched-filter image.

A data column of ROWS samples enters as a stream, one sample per accepted cycle, and a pulse marks its first sample. Every sample is broadcast to all elements at once. Each element multiplies the sample by its coefficient in signed fixed point and adds the partial sum handed down from its neighbour. The partial sums move one element along the chain per step, so the element at the end of the chain releases the finished result rows one after another in row order. Once the last sample has gone in, the block generates HALF zero-padding steps by itself to finish the rows near the bottom edge.

Top module: `band_toeplitz_mac`

## Requirements
- R1: After reset out_valid is low and every coefficient is zero, so a column streamed before any preload gives ROWS results that are all zero.
- R2: A write with coef_we stores coef_val as the coefficient of diagonal index k = coef_idx. Diagonal k multiplies data row i+k−HALF into result row i, so k = HALF is the main diagonal. A write with an index above 2·HALF changes nothing.
- R3: A coefficient write is ignored while a column is in progress. That period runs from the cycle after an accepted start pulse until the column's last step has left the input register.
- R4: Values are signed Q9.23. Each product is the full signed 64-bit product cut to its bits [54:23], which is an arithmetic shift right by 23 that rounds toward minus infinity. Sums wrap modulo 2^32, with no rounding and no saturation.
- R5: Result row i equals the sum over k of c[k]·D[i+k−HALF]. Any term whose data row lies outside 0..ROWS−1 counts as zero.
- R6: A sample taken at a rising edge forms its result step in the input register at that edge and in the accumulator at the next edge. The result for row i is therefore visible after the second edge counted from the edge that takes sample i+HALF. For the last HALF rows, that sample is one of the self-generated zero-padding steps, which come on the cycles straight after the last sample.
- R7: Dropping in_valid in the middle of a column pauses it. No result is produced during the pause, and the column continues unchanged when samples resume.
- R8: in_valid without a start pulse while no column is active is ignored. Any input offered during the HALF padding cycles is also ignored, start pulse included.
- R9: A start pulse in the middle of a column abandons that column and begins a new one. Results of the old column whose samples were all taken still appear, ahead of the new column's results.
- R10: A full column gives exactly ROWS results in row order. No result is emitted for the first HALF steps of a column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | IW | Diagonal index of the write (IW = clog2(2·HALF+1)) |
| coef_val | input | 32 | Q9.23 coefficient value |
| in_valid | input | 1 | A data sample is offered |
| in_sop | input | 1 | Offered sample is row 0 of a new column |
| in_data | input | 32 | Q9.23 data sample |
| out_valid | output | 1 | out_data holds a result row |
| out_data | output | 32 | Q9.23 result row |

## Verification
For an uninterrupted column whose start pulse is driven in bench cycle c0, result row i is due in cycle c0+i+HALF+2. That count covers the input register and the accumulator, and the bench checks the stamped arrival cycle of every row against it. With stalls or restarts, only the order and values of the results are compared, because a pause moves every later result back by the length of the pause. Outputs are sampled on the falling edge, so each result is read half a cycle after the edge that registers it.

// File: rtl/btm_pkg.sv
package btm_pkg;
  localparam int unsigned QW = 32;
  localparam int unsigned QF = 23;
  localparam int unsigned PW = 2 * QW;

  typedef logic signed [QW-1:0] q_t;

  // signed fixed-point product, 2*QW wide, cut back to QW bits
  function automatic q_t q_mul(input q_t a, input q_t b);
    logic signed [PW-1:0] full;
    full = PW'(a) * PW'(b);
    return full[QF +: QW];
  endfunction
endpackage

// File: rtl/btm_ctrl.sv
module btm_ctrl #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_sop,
  output logic step,
  output logic clr,
  output logic emit,
  output logic flushing,
  output logic col_act
);
  localparam int unsigned SPAN = ROWS + HALF;
  localparam int unsigned CW   = $clog2(SPAN + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] jidx;
  logic          take;

  always_comb begin
    flushing = col_act && (cnt >= CW'(ROWS));
    take     = in_valid && !flushing && (in_sop || col_act);
    step     = take || flushing;
    clr      = take && in_sop;
    jidx     = clr ? '0 : cnt;
    emit     = (jidx >= CW'(HALF));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      col_act <= 1'b0;
    end else if (step) begin
      cnt     <= jidx + 1'b1;
      col_act <= (int'(jidx) + 1) < int'(SPAN);
    end
  end
endmodule

// File: rtl/btm_coef_bank.sv
module btm_coef_bank import btm_pkg::*; #(
  parameter int unsigned NPE = 5,
  parameter int unsigned IW  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [QW-1:0]          wr_val,
  input  logic                   lock,
  output logic [NPE-1:0][QW-1:0] coefs
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      coefs <= '0;
    else if (wr_en && !lock && (int'(wr_idx) < int'(NPE)))
      coefs[wr_idx] <= wr_val;
  end
endmodule

// File: rtl/btm_pe.sv
module btm_pe import btm_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clr,
  input  q_t   coef,
  input  q_t   x,
  input  q_t   r_in,
  output q_t   acc
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      acc <= '0;
    else if (step)
      acc <= q_mul(coef, x) + (clr ? q_t'(0) : r_in);
  end
endmodule

// File: rtl/band_toeplitz_mac.sv
module band_toeplitz_mac import btm_pkg::*; #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned HALF = 2,
  localparam int unsigned NPE = 2 * HALF + 1,
  localparam int unsigned IW  = (NPE > 1) ? $clog2(NPE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coef_we,
  input  logic [IW-1:0] coef_idx,
  input  logic [QW-1:0] coef_val,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic [QW-1:0] in_data,
  output logic          out_valid,
  output logic [QW-1:0] out_data
);
  logic step, clr, emit, flushing, col_act;
  logic step_q, clr_q, emit_q, busy;
  q_t   x_q;
  logic [NPE-1:0][QW-1:0] coefs;
  logic [NPE:0][QW-1:0]   chain;

  btm_ctrl #(.ROWS(ROWS), .HALF(HALF)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .step(step), .clr(clr), .emit(emit), .flushing(flushing), .col_act(col_act)
  );

  assign busy = col_act || step_q;

  btm_coef_bank #(.NPE(NPE), .IW(IW)) i_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_idx(coef_idx),
    .wr_val(coef_val), .lock(busy), .coefs(coefs)
  );

  // input register: broadcast sample plus step flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q    <= 1'b0;
      clr_q     <= 1'b0;
      emit_q    <= 1'b0;
      x_q       <= '0;
      out_valid <= 1'b0;
    end else begin
      step_q    <= step;
      clr_q     <= clr;
      emit_q    <= emit;
      x_q       <= flushing ? q_t'(0) : q_t'(in_data);
      out_valid <= step_q && emit_q;
    end
  end

  assign chain[NPE] = '0;

  // element p holds the diagonal that meets the sample p steps late
  for (genvar p = 0; p < NPE; p++) begin : g_pe
    btm_pe i_pe (
      .clk(clk), .rst_n(rst_n), .step(step_q), .clr(clr_q),
      .coef(coefs[NPE-1-p]), .x(x_q), .r_in(chain[p+1]), .acc(chain[p])
    );
  end

  assign out_data = chain[0];
endmodule

// File: rtl/btm_chk.sv
module btm_chk #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned HALF = 2,
  parameter int unsigned NPE  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_sop,
  input logic                  step,
  input logic                  clr,
  input logic                  step_q,
  input logic                  clr_q,
  input logic                  flushing,
  input logic                  busy,
  input logic                  out_valid,
  input logic [NPE-1:0][31:0]  coefs
);
  int unsigned seen;
  logic        clr_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen  <= 0;
      clr_d <= 1'b0;
    end else begin
      clr_d <= step_q && clr_q;
      seen  <= (clr_d ? 0 : seen) + (out_valid ? 1 : 0);
    end
  end

  // R3
  coef_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(coefs));

  // R6
  result_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(step, 2));

  // R8
  pad_sop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flushing && in_valid && in_sop) |=> !clr_q);

  // R10
  head_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((HALF > 0) && step && clr) |=> ##1 !out_valid);

  // R10
  col_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_d ? 0 : seen) + (out_valid ? 1 : 0)) <= ROWS);
endmodule

bind band_toeplitz_mac btm_chk #(.ROWS(ROWS), .HALF(HALF), .NPE(NPE)) i_btm_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
  .step(step), .clr(clr), .step_q(step_q), .clr_q(clr_q),
  .flushing(flushing), .busy(busy), .out_valid(out_valid), .coefs(coefs)
);

// File: tb/test_band_toeplitz_mac.sv
module test_band_toeplitz_mac;
  localparam int ROWS = 16;
  localparam int A    = 2;
  localparam int NPE  = 2 * A + 1;
  localparam int IW   = 3;
  localparam logic [31:0] ONE = 32'h0080_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          coef_we = 1'b0;
  logic [IW-1:0] coef_idx = '0;
  logic [31:0]   coef_val = '0;
  logic          in_valid = 1'b0;
  logic          in_sop = 1'b0;
  logic [31:0]   in_data = '0;
  logic          out_valid;
  logic [31:0]   out_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [31:0] col [0:ROWS-1];
  logic [31:0] mc  [0:NPE-1];
  logic [31:0] exp_data [0:63];
  int          exp_n = 0;
  logic [31:0] got_data [0:63];
  int          got_cyc  [0:63];
  int          got_n = 0;

  band_toeplitz_mac #(.ROWS(ROWS), .HALF(A)) i_band_toeplitz_mac (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_idx(coef_idx),
    .coef_val(coef_val), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && got_n < 64) begin
      got_data[got_n] = out_data;
      got_cyc[got_n]  = cyc;
      got_n++;
    end
  end

  function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    longint p;
    p = longint'($signed(a)) * longint'($signed(b));
    return 32'(p >>> 23);
  endfunction

  function automatic logic [31:0] ref_out(input int i, input int len);
    logic [31:0] s = '0;
    for (int k = 0; k < NPE; k++) begin
      int r = i + k - A;
      if (r >= 0 && r < len) s = s + ref_mul(mc[k], col[r]);
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic add_exp(input int len, input int nout);
    for (int i = 0; i < nout; i++) begin
      exp_data[exp_n] = ref_out(i, len);
      exp_n++;
    end
  endtask

  task automatic clear_logs();
    got_n = 0;
    exp_n = 0;
  endtask

  task automatic compare_all(input string req);
    chk(got_n == exp_n, {req, " count"}, 32'(got_n), 32'(exp_n));
    for (int i = 0; i < got_n && i < exp_n; i++)
      chk(got_data[i] == exp_data[i], req, got_data[i], exp_data[i]);
  endtask

  task automatic chk_lat(input int c0, input string req);
    for (int i = 0; i < got_n; i++)
      chk(got_cyc[i] == c0 + 2 + i + A, req, 32'(got_cyc[i]), 32'(c0 + 2 + i + A));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; coef_we = 1'b0;
    end
  endtask

  task automatic wr_coef(input int idx, input logic [31:0] v);
    @(negedge clk);
    coef_we = 1'b1; coef_idx = IW'(idx); coef_val = v;
    @(negedge clk);
    coef_we = 1'b0;
    if (idx < NPE) mc[idx] = v;
  endtask

  task automatic rand_col();
    for (int r = 0; r < ROWS; r++) col[r] = $urandom;
  endtask

  // streams col[0..len-1]; a write attempt rides on sample wr_at
  task automatic drive_col(input int len, input int stall_pct, input bit noise,
                           input int wr_at, input int widx, input logic [31:0] wval,
                           output int c0);
    c0 = 0;
    for (int s = 0; s < len; s++) begin
      @(negedge clk);
      coef_we = 1'b0;
      if (s > 0 && stall_pct > 0) begin
        while (int'($urandom % 100) < stall_pct) begin
          in_valid = 1'b0; in_sop = 1'b0; in_data = $urandom;
          @(negedge clk);
        end
      end
      in_valid = 1'b1; in_sop = (s == 0); in_data = col[s];
      if (s == 0) c0 = cyc;
      coef_we = (s == wr_at); coef_idx = IW'(widx); coef_val = wval;
    end
    if (len == ROWS) begin
      for (int f = 0; f < A; f++) begin
        @(negedge clk);
        coef_we = 1'b0;
        in_valid = noise; in_sop = noise; in_data = $urandom;
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; coef_we = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R6 watchdog act=%0d exp=finished", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0;
    void'($urandom(32'd7321));
    for (int k = 0; k < NPE; k++) mc[k] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 32'd0);

    // R1: no preload, all results zero
    clear_logs(); rand_col(); add_exp(ROWS, ROWS);
    drive_col(ROWS, 0, 0, -1, 0, 0, c0); idle(A + 4);
    compare_all("R1");
    chk(got_data[3] == 32'd0, "R1 zero result", got_data[3], 32'd0);

    // R2 R5: main diagonal = 1.0 is identity
    wr_coef(A, ONE);
    clear_logs(); rand_col(); add_exp(ROWS, ROWS);
    drive_col(ROWS, 0, 0, -1, 0, 0, c0); idle(A + 4);
    compare_all("R5 identity");
    chk(got_data[7] == col[7], "R2 main diagonal", got_data[7], col[7]);
    chk_lat(c0, "R6 latency");

    // R2 R5: diagonal A+1 picks the next row, bottom row padded with zero
    wr_coef(A, 32'd0); wr_coef(A + 1, ONE);
    clear_logs(); rand_col(); add_exp(ROWS, ROWS);
    drive_col(ROWS, 0, 0, -1, 0, 0, c0); idle(A + 4);
    compare_all("R5 shift");
    chk(got_data[0] == col[1], "R2 diagonal orientation", got_data[0], col[1]);
    chk(got_data[ROWS-1] == 32'd0, "R5 bottom padding", got_data[ROWS-1], 32'd0);

    // R2: index above 2*HALF changes nothing
    wr_coef(7, 32'h1234_5678);
    clear_logs(); rand_col(); add_exp(ROWS, ROWS);
    drive_col(ROWS, 0, 0, -1, 0, 0, c0); idle(A + 4);
    compare_all("R2 bad index");
    chk(got_data[4] == col[5], "R2 bad index", got_data[4], col[5]);

    // R4: wraparound and floor truncation
    wr_coef(A + 1, 32'd0); wr_coef(A, 32'h7FFF_FFFF);
    clear_logs(); rand_col();
    col[0] = 32'h7FFF_FFFF; col[1] = 32'hFFFF_FFFF; col[2] = 32'h8000_0000;
    add_exp(ROWS, ROWS);
    drive_col(ROWS, 0, 0, -1, 0, 0, c0); idle(A + 4);
    compare_all("R4");
    chk(got_data[0] == 32'hFFFF_FE00, "R4 wrap", got_data[0], 32'hFFFF_FE00);
    chk(got_data[1] == 32'hFFFF_FF00, "R4 floor", got_data[1], 32'hFFFF_FF00);

    // R5 R6 R7 R8: random coefficients and data, stalls and pad-cycle noise
    for (int t = 0; t < 8; t++) begin
      for (int k = 0; k < NPE; k++) wr_coef(k, $urandom);
      clear_logs(); rand_col(); add_exp(ROWS, ROWS);
      drive_col(ROWS, (t % 2) ? 40 : 0, (t % 4) >= 2, -1, 0, 0, c0); idle(A + 4);
      if (t % 2) compare_all("R7 stall");
      else if ((t % 4) >= 2) compare_all("R8 pad noise");
      else compare_all("R5 random");
      if ((t % 2) == 0) chk_lat(c0, "R6 latency");
    end

    // R3: write during a column is dropped, now and later
    clear_logs(); rand_col(); add_exp(ROWS, ROWS);
    drive_col(ROWS, 0, 0, 4, A, 32'h0555_0000, c0); idle(A + 4);
    compare_all("R3 during");
    clear_logs(); rand_col(); add_exp(ROWS, ROWS);
    drive_col(ROWS, 0, 0, -1, 0, 0, c0); idle(A + 4);
    compare_all("R3 after");

    // R8: samples with no start pulse while idle
    clear_logs();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_data = $urandom;
    end
    idle(6);
    chk(got_n == 0, "R8 idle samples", 32'(got_n), 32'd0);

    // R9: restart after five samples
    clear_logs(); rand_col(); add_exp(5, 5 - A);
    drive_col(5, 0, 0, -1, 0, 0, c0);
    rand_col(); add_exp(ROWS, ROWS);
    drive_col(ROWS, 0, 0, -1, 0, 0, c0); idle(A + 4);
    compare_all("R9 restart");

    // R10: count and order of a full column with stalls
    clear_logs(); rand_col(); add_exp(ROWS, ROWS);
    drive_col(ROWS, 25, 1, -1, 0, 0, c0); idle(A + 4);
    chk(got_n == ROWS, "R10 count", 32'(got_n), 32'(ROWS));
    compare_all("R10 order");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule